// File: doc/BRIEF.md
# Capture-Only Test Access Port for a Memory Device

This block is the boundary-test port of a memory device. A serial test clock, a mode-select line and a serial data input step a standard sixteen-state test controller. A three-bit instruction then chooses one data path to sit between the serial input and the serial output. The paths are a fixed 32-bit identification word, a one-bit bypass stage and a boundary register. The boundary register photographs a parallel bus of sampled device pin values.

Every instruction only observes. None can preload pins, drive them, or reach the memory core. Two of the boundary instructions also raise an output that places the device outputs in high impedance. Going through the data-update state never changes anything. Test equipment uses the port to read the identification word, to snapshot pin states, and to isolate the part's outputs during board test.

Top module: `mem_tap`

## Requirements
- R1: An active-low `trst_n`, or five consecutive rising `tck` edges with `tms` high from any state, puts the controller in Test-Logic-Reset. That state makes IDCODE (code 001) the active instruction, with `force_hiz` low and `tdo_oe` low.
- R2: The controller follows the standard sixteen-state test-port diagram, sampling `tms` on each rising `tck` edge.
- R3: In Capture-IR the instruction shift register loads 3'b001. In Shift-IR it shifts `tdi` in at the most significant bit and presents bit 0 on `tdo`, so a capture is read out as 1, 0, 0.
- R4: A newly shifted instruction takes effect only after Update-IR. Until then, the previous instruction keeps controlling `force_hiz` and the data path, including while the controller waits in Pause-IR.
- R5: Under IDCODE (001), Capture-DR loads the 32-bit parameter `ID_WORD`, whose bit 0 is 1. Shift-DR shifts it out least significant bit first.
- R6: Under SAMPLE (100), Capture-DR copies `pin_sample[i]` into boundary bit i. Shift-DR sends bit 0 out first, and `force_hiz` stays low.
- R7: Under the all-zeros code (000), the boundary register captures and shifts exactly as under SAMPLE, and `force_hiz` is high.
- R8: Under SAMPLE Z (010), the boundary register is the selected path and `force_hiz` is high.
- R9: Code 111, and the unused codes 011, 101 and 110, select a one-bit bypass stage that captures 0. `force_hiz` stays low under all four.
- R10: Passing through Update-DR under any instruction changes neither `force_hiz` nor `tdo_oe`, and the register contents stay as they were.
- R11: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| pin_sample | input | BSR_LEN | Parallel sampled device pin values |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for tdo |
| force_hiz | output | 1 | Forces the device outputs to high impedance |

## Verification
The bench catches an instruction that takes effect too early by parking the controller in Pause-IR with a new code shifted in and confirming `force_hiz` has not moved yet. It loads each of the eight codes in turn. A wrong decode of the unused codes therefore shows up as a 16-bit boundary read-out or an ID read-out where a delayed one-bit bypass echo was expected. A `tdo` launched on the rising edge shows a new bit just after the rising edge instead of just after the falling edge. Reaching reset through five `tms` highs, rather than through `trst_n`, exposes a controller that skips the return to IDCODE.

// File: rtl/mem_tap.sv
module mem_tap #(
  parameter int          BSR_LEN = 16,
  parameter logic [31:0] ID_WORD = 32'h1A5C_3E45
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               force_hiz
);

  typedef enum logic [3:0] {
    TLR  = 4'h0, RTI  = 4'h1, SDR  = 4'h2, CDR  = 4'h3,
    SHDR = 4'h4, E1D  = 4'h5, PDR  = 4'h6, E2D  = 4'h7,
    UDR  = 4'h8, SIR  = 4'h9, CIR  = 4'hA, SHIR = 4'hB,
    E1I  = 4'hC, PIR  = 4'hD, E2I  = 4'hE, UIR  = 4'hF
  } tap_st_t;

  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_IDCODE = 3'b001;
  localparam logic [2:0] OP_SAMPZ  = 3'b010;
  localparam logic [2:0] OP_SAMPLE = 3'b100;

  tap_st_t            state, state_nx;
  logic [2:0]         ir_sh, ir;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh;
  logic               byp;
  logic               sel_id, sel_bsr, shifting, tdo_src;

  always_comb begin
    unique case (state)
      TLR:  state_nx = tms ? TLR  : RTI;
      RTI:  state_nx = tms ? SDR  : RTI;
      SDR:  state_nx = tms ? SIR  : CDR;
      CDR:  state_nx = tms ? E1D  : SHDR;
      SHDR: state_nx = tms ? E1D  : SHDR;
      E1D:  state_nx = tms ? UDR  : PDR;
      PDR:  state_nx = tms ? E2D  : PDR;
      E2D:  state_nx = tms ? UDR  : SHDR;
      UDR:  state_nx = tms ? SDR  : RTI;
      SIR:  state_nx = tms ? TLR  : CIR;
      CIR:  state_nx = tms ? E1I  : SHIR;
      SHIR: state_nx = tms ? E1I  : SHIR;
      E1I:  state_nx = tms ? UIR  : PIR;
      PIR:  state_nx = tms ? E2I  : PIR;
      E2I:  state_nx = tms ? UIR  : SHIR;
      UIR:  state_nx = tms ? SDR  : RTI;
      default: state_nx = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= TLR;
    else         state <= state_nx;

  assign sel_id    = (ir == OP_IDCODE);
  assign sel_bsr   = (ir == OP_EXTEST) || (ir == OP_SAMPZ) || (ir == OP_SAMPLE);
  assign force_hiz = (ir == OP_EXTEST) || (ir == OP_SAMPZ);
  assign shifting  = (state == SHIR) || (state == SHDR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= 3'b001;
      ir    <= OP_IDCODE;
    end else begin
      if (state == CIR)       ir_sh <= 3'b001;
      else if (state == SHIR) ir_sh <= {tdi, ir_sh[2:1]};
      if (state == TLR)       ir <= OP_IDCODE;
      else if (state == UIR)  ir <= ir_sh;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sh  <= '0;
      bsr_sh <= '0;
      byp    <= 1'b0;
    end else if (state == CDR) begin
      if (sel_id)       id_sh  <= ID_WORD;
      else if (sel_bsr) bsr_sh <= pin_sample;
      else              byp    <= 1'b0;
    end else if (state == SHDR) begin
      if (sel_id)       id_sh  <= {tdi, id_sh[31:1]};
      else if (sel_bsr) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
      else              byp    <= tdi;
    end
  end

  assign tdo_src = (state == SHIR) ? ir_sh[0] :
                   sel_id          ? id_sh[0] :
                   sel_bsr         ? bsr_sh[0] : byp;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shifting;
      tdo    <= shifting ? tdo_src : 1'b0;
    end
  end

endmodule

// File: rtl/mem_tap_chk.sv
module mem_tap_chk #(
  parameter int          BSR_LEN = 16,
  parameter logic [31:0] ID_WORD = 32'h1A5C_3E45
) (
  input logic               tck,
  input logic               trst_n,
  input logic [3:0]         st,
  input logic [2:0]         ir_sh,
  input logic [2:0]         ir,
  input logic [31:0]        id_sh,
  input logic [BSR_LEN-1:0] bsr_sh,
  input logic               tdo_oe,
  input logic               force_hiz
);
  localparam logic [3:0] S_TLR = 4'h0, S_CDR = 4'h3, S_SHDR = 4'h4, S_UDR = 4'h8;
  localparam logic [3:0] S_CIR = 4'hA, S_SHIR = 4'hB, S_UIR = 4'hF;

  // R1
  reset_to_id_chk: assert property (@(posedge tck) disable iff (!trst_n)
    st == S_TLR |=> ir == 3'b001);

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    st == S_CIR |=> ir_sh == 3'b001);

  // R4
  ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st != S_UIR && st != S_TLR) |=> ($stable(ir) && $stable(force_hiz)));

  // R5
  id_lsb_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_CDR && ir == 3'b001) |=> id_sh[0] == 1'b1);

  // R10
  update_dr_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
    st == S_UDR |=> ($stable(bsr_sh) && $stable(id_sh) && $stable(force_hiz)));

  // R11
  tdo_enable_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (st == S_SHIR || st == S_SHDR));

  // R5
  id_param_chk: assert property (@(posedge tck) ID_WORD[0] == 1'b1 || !trst_n);
endmodule

bind mem_tap mem_tap_chk #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_chk (
  .tck(tck), .trst_n(trst_n), .st(state), .ir_sh(ir_sh), .ir(ir),
  .id_sh(id_sh), .bsr_sh(bsr_sh), .tdo_oe(tdo_oe), .force_hiz(force_hiz)
);

// File: tb/mem_tap_tb.sv
module mem_tap_tb;
  localparam int          BL  = 16;
  localparam logic [31:0] IDV = 32'h1A5C_3E45;
  // {code[2:0], expected force_hiz, kind: 0 bypass, 1 id, 2 boundary}
  localparam logic [5:0] VEC [8] = '{
    6'b000_1_10, 6'b001_0_01, 6'b010_1_10, 6'b011_0_00,
    6'b100_0_10, 6'b101_0_00, 6'b110_0_00, 6'b111_0_00
  };

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BL-1:0] pins = '0;
  logic tdo, tdo_oe, force_hiz;
  int n_chk = 0, n_bad = 0;

  mem_tap #(.BSR_LEN(BL), .ID_WORD(IDV)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_sample(pins),
    .tdo(tdo), .tdo_oe(tdo_oe), .force_hiz(force_hiz)
  );

  always #4 tck = ~tck;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, code[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0]  code, cap;
    logic [31:0] d, din;
    string       rq;
    repeat (2) @(negedge tck);
    #1;
    chk("R1 oe in reset", 32'(tdo_oe), 0);
    chk("R1 hiz in reset", 32'(force_hiz), 0);
    trst_n = 1'b1;
    step(0, 0);
    scan_dr(32, 32'h0, d);
    chk("R1 R5 id after trst", d, IDV);
    chk("R5 id lsb", 32'(d[0]), 1);

    for (int i = 0; i < 8; i++) begin
      code = VEC[i][5:3];
      pins = 16'h3C5A ^ 16'(i * 16'h1111);
      din  = 32'hC0DE_0000 | 32'(i);
      scan_ir(code, cap);
      chk("R3 ir capture", 32'(cap), 32'b001);
      rq = (VEC[i][1:0] == 2'd1) ? "R5" : (VEC[i][1:0] == 2'd0) ? "R9" :
           (code == 3'b000) ? "R7" : (code == 3'b010) ? "R8" : "R6";
      chk({rq, " hiz"}, 32'(force_hiz), 32'(VEC[i][2]));
      case (VEC[i][1:0])
        2'd1: begin scan_dr(32, din, d); chk({rq, " id"}, d, IDV); end
        2'd2: begin scan_dr(BL, din, d); chk({rq, " boundary"}, d, 32'(pins)); end
        default: begin scan_dr(8, din, d); chk({rq, " bypass"}, d, {24'b0, din[6:0], 1'b0}); end
      endcase
    end

    scan_ir(3'b001, cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 0); step(0, 1); step(1, 0);
    step(0, 0);
    chk("R4 pause-ir hiz", 32'(force_hiz), 0);
    step(1, 0); step(1, 0); step(0, 0);
    chk("R4 R8 after update", 32'(force_hiz), 1);

    scan_ir(3'b000, cap);
    step(1, 0); step(0, 0); step(1, 0); step(1, 0);
    chk("R10 extest update hiz", 32'(force_hiz), 1);
    chk("R10 extest update oe", 32'(tdo_oe), 0);
    step(0, 0);
    chk("R10 extest idle hiz", 32'(force_hiz), 1);
    scan_ir(3'b100, cap);
    step(1, 0); step(0, 0); step(1, 0); step(1, 0);
    chk("R10 sample update hiz", 32'(force_hiz), 0);
    step(0, 0);
    chk("R10 sample idle hiz", 32'(force_hiz), 0);

    scan_ir(3'b001, cap);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R11 oe in shift", 32'(tdo_oe), 1);
    chk("R11 bit0", 32'(tdo), 32'(IDV[0]));
    tms = 0; tdi = 0;
    @(posedge tck); #1;
    chk("R11 held after rise", 32'(tdo), 32'(IDV[0]));
    @(negedge tck); #1;
    chk("R11 bit1 after fall", 32'(tdo), 32'(IDV[1]));
    step(1, 0); step(1, 0); step(0, 0);
    chk("R11 oe in idle", 32'(tdo_oe), 0);

    scan_ir(3'b111, cap);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R1 R2 tms reset hiz", 32'(force_hiz), 0);
    step(0, 0);
    scan_dr(32, 32'h0, d);
    chk("R1 R2 id after tms reset", d, IDV);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule